// File: doc/BRIEF.md
# Receive Buffer Flush Latency Timer

This block decides when a partly filled receive byte buffer is handed to an upstream packet reader. Without it, data would leave only once the buffer is full. The block follows the buffer's occupancy from the write strobe (a byte entering) and the pop strobe (a byte leaving). While data is pending, it counts millisecond ticks against a programmable timeout. It raises a flush request when the timeout runs out, when the buffer becomes full, or when a byte equal to the programmed event character arrives while that feature is enabled.

The request stays up until the reader acknowledges it. A small register interface sets the timeout in millisecond steps, the event character and the event enable. A three-state machine ties these parts together:
- IDLE: the buffer is empty and the timer is stopped.
- PEND: data is waiting and the timer runs.
- REQ: a flush is requested and the block waits for the acknowledge.

Transitions:
- IDLE→PEND on the first accepted byte.
- IDLE→REQ on an accepted event character.
- PEND→REQ on full, event or expiry.
- PEND→IDLE when the buffer drains.
- REQ→PEND on an acknowledge with data left.
- REQ→IDLE on an acknowledge with the buffer empty.

Top module: `rxflush_ctrl`

## Requirements
- R1: After reset, flush_req is 0, flush_cause is 0, level is 0, buf_empty is 1 and buf_full is 0.
- R2: Occupancy: an accepted write adds 1 and an accepted pop subtracts 1. Both in the same cycle leave level unchanged. A write while buf_full is 1 is ignored, and a pop while buf_empty is 1 is ignored. level never exceeds DEPTH (384).
- R3: Registers are written with cfg_we, using cfg_addr 0 for the timeout in ms, 1 for the event character and 2 for the event enable (bit 0). Address 3 is unused. With data pending, the Nth ms_tick pulse after the last accepted write raises flush_req in the cycle after that tick, where N is the programmed timeout. flush_cause is then 1 (timeout); the other codes are 2 (full) and 3 (event).
- R4: A programmed timeout of 0 behaves as 1 ms.
- R5: Every accepted write restarts the timeout count from zero.
- R6: While the buffer is empty the timer does not count, and no flush is requested. A buffer drained by pops without a flush returns to idle.
- R7: When level reaches DEPTH, flush_req rises one cycle later with flush_cause 2.
- R8: With the event enable set, an accepted byte equal to the event character raises flush_req in the next cycle with flush_cause 3, including on an empty buffer. With the enable clear, the same byte causes no flush.
- R9: flush_req and flush_cause hold until flush_ack. Expiries and event characters arriving meanwhile are absorbed. After the acknowledge the timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| wr_valid | input | 1 | A byte enters the buffer |
| wr_data | input | 8 | Value of the entering byte |
| rd_pop | input | 1 | Reader removes one byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 8 | Register write data |
| flush_ack | input | 1 | Reader acknowledges the flush |
| flush_req | output | 1 | Flush request |
| flush_cause | output | 2 | Reason for the pending request |
| level | output | 9 | Bytes held in the buffer |
| buf_empty | output | 1 | Buffer holds no byte |
| buf_full | output | 1 | Buffer holds DEPTH bytes |

## Verification
The hardest situation to reach is an acknowledge that leaves the buffer completely full. The machine then drops to PEND and must raise a fresh full request on the very next cycle. The stimulus writes 384 bytes, tries one extra write while full, and acknowledges without popping. It then acknowledges again with a simultaneous pop. A second subtle point is a timeout landing while a request is already pending. The bench keeps ticking during the request and expects no second rise in the scoreboard.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_REQ  = 2'd2
    } rxf_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_TIMEOUT = 2'd1,
        CAUSE_FULL    = 2'd2,
        CAUSE_EVENT   = 2'd3
    } rxf_cause_e;

    localparam logic [1:0] ADDR_TMO    = 2'd0;
    localparam logic [1:0] ADDR_EVCHAR = 2'd1;
    localparam logic [1:0] ADDR_EVEN   = 2'd2;

endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs #(
    parameter int TMO_W   = 8,
    parameter int DATA_W  = 8,
    parameter int TMO_RST = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [TMO_W-1:0]  period,
    output logic [DATA_W-1:0] ev_char,
    output logic              ev_en
);
    import rxf_pkg::*;

    logic [TMO_W-1:0] tmo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q   <= TMO_W'(TMO_RST);
            ev_char <= '0;
            ev_en   <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                ADDR_TMO:    tmo_q   <= TMO_W'(cfg_wdata);
                ADDR_EVCHAR: ev_char <= cfg_wdata;
                ADDR_EVEN:   ev_en   <= cfg_wdata[0];
                default:     ;
            endcase
        end
    end

    // a zero timeout is promoted to the shortest step
    assign period = (tmo_q == '0) ? TMO_W'(1) : tmo_q;

endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
    parameter int DEPTH = 384,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             rd_pop,
    output logic             wr_acc,
    output logic [LVL_W-1:0] level,
    output logic [LVL_W-1:0] level_nxt,
    output logic             empty,
    output logic             full
);
    logic pop_acc;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign wr_acc  = wr_valid && !full;
    assign pop_acc = rd_pop && !empty;

    always_comb begin
        level_nxt = level;
        if (wr_acc && !pop_acc) begin
            level_nxt = level + LVL_W'(1);
        end else if (pop_acc && !wr_acc) begin
            level_nxt = level - LVL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            level <= level_nxt;
        end
    end

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             ms_tick,
    input  logic [TMO_W-1:0] period,
    output logic             expire
);
    logic [TMO_W-1:0] cnt;
    logic [TMO_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + (TMO_W + 1)'(1);
    assign expire  = run && !restart && ms_tick && (cnt_inc >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart || expire) begin
            cnt <= '0;
        end else if (ms_tick) begin
            cnt <= cnt_inc[TMO_W-1:0];
        end
    end

endmodule

// File: rtl/rxf_evmatch.sv
module rxf_evmatch #(
    parameter int DATA_W = 8
) (
    input  logic              wr_acc,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] ev_char,
    input  logic              ev_en,
    output logic              ev_hit
);
    logic [DATA_W-1:0] bit_eq;

    for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
        assign bit_eq[i] = ~(wr_data[i] ^ ev_char[i]);
    end

    assign ev_hit = wr_acc && ev_en && (&bit_eq);

endmodule

// File: rtl/rxflush_ctrl.sv
module rxflush_ctrl #(
    parameter int DEPTH   = 384,
    parameter int DATA_W  = 8,
    parameter int TMO_W   = 8,
    parameter int TMO_RST = 16,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_pop,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              flush_ack,
    output logic              flush_req,
    output logic [1:0]        flush_cause,
    output logic [LVL_W-1:0]  level,
    output logic              buf_empty,
    output logic              buf_full
);
    import rxf_pkg::*;

    rxf_state_e       state, state_nxt;
    rxf_cause_e       cause_q, trig_cause;
    logic [TMO_W-1:0] period;
    logic [DATA_W-1:0] ev_char;
    logic             ev_en;
    logic             wr_acc;
    logic [LVL_W-1:0] level_nxt;
    logic             tmr_expire;
    logic             ev_hit;

    rxf_cfg_regs #(.TMO_W(TMO_W), .DATA_W(DATA_W), .TMO_RST(TMO_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .period(period), .ev_char(ev_char), .ev_en(ev_en)
    );

    rxf_level #(.DEPTH(DEPTH)) u_lvl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_pop(rd_pop),
        .wr_acc(wr_acc), .level(level), .level_nxt(level_nxt),
        .empty(buf_empty), .full(buf_full)
    );

    rxf_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(state == ST_PEND), .restart(wr_acc),
        .ms_tick(ms_tick), .period(period), .expire(tmr_expire)
    );

    rxf_evmatch #(.DATA_W(DATA_W)) u_ev (
        .wr_acc(wr_acc), .wr_data(wr_data), .ev_char(ev_char),
        .ev_en(ev_en), .ev_hit(ev_hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and trigger reason
    always_comb begin
        state_nxt  = state;
        trig_cause = CAUSE_NONE;
        unique case (state)
            ST_IDLE: begin
                if (ev_hit) begin
                    state_nxt  = ST_REQ;
                    trig_cause = CAUSE_EVENT;
                end else if (wr_acc) begin
                    state_nxt = ST_PEND;
                end
            end
            ST_PEND: begin
                if (buf_full) begin
                    state_nxt  = ST_REQ;
                    trig_cause = CAUSE_FULL;
                end else if (ev_hit) begin
                    state_nxt  = ST_REQ;
                    trig_cause = CAUSE_EVENT;
                end else if (level_nxt == '0) begin
                    state_nxt = ST_IDLE;
                end else if (tmr_expire) begin
                    state_nxt  = ST_REQ;
                    trig_cause = CAUSE_TIMEOUT;
                end
            end
            ST_REQ: begin
                if (flush_ack) begin
                    state_nxt = (level_nxt == '0) ? ST_IDLE : ST_PEND;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
        end else if (state_nxt == ST_REQ && state != ST_REQ) begin
            cause_q <= trig_cause;
        end else if (state_nxt != ST_REQ) begin
            cause_q <= CAUSE_NONE;
        end
    end

    assign flush_req   = (state == ST_REQ);
    assign flush_cause = cause_q;

endmodule

// File: rtl/rxf_checks.sv
module rxf_checks #(
    parameter int DEPTH = 384,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic             rd_pop,
    input logic             flush_ack,
    input logic             flush_req,
    input logic [1:0]       flush_cause,
    input logic [LVL_W-1:0] level,
    input logic             buf_empty,
    input logic             buf_full
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_ack |=> flush_req); // R9

    AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req && !flush_ack |=> $stable(flush_cause)); // R9

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> flush_cause != 2'd0); // R3

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R2

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && wr_valid && !rd_pop |=> level == $past(level)); // R2

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty && rd_pop && !wr_valid |=> buf_empty); // R2

    AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full && !flush_req |=> flush_req); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty && !flush_req && !wr_valid |=> !flush_req); // R6

endmodule

bind rxflush_ctrl rxf_checks #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_pop(rd_pop),
    .flush_ack(flush_ack), .flush_req(flush_req), .flush_cause(flush_cause),
    .level(level), .buf_empty(buf_empty), .buf_full(buf_full)
);

// File: tb/rxflush_ctrl_test.sv
module rxflush_ctrl_test;
    localparam int DEPTH = 384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_pop = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       flush_ack = 1'b0;
    logic       flush_req;
    logic [1:0] flush_cause;
    logic [8:0] level;
    logic       buf_empty;
    logic       buf_full;

    int errors = 0;
    int checks = 0;
    logic [1:0] exp_q[$];
    logic mon_prev = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    rxflush_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_pop(rd_pop), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .flush_ack(flush_ack), .flush_req(flush_req),
        .flush_cause(flush_cause), .level(level), .buf_empty(buf_empty),
        .buf_full(buf_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d; step(); wr_valid = 1'b0;
    endtask

    task automatic tick();
        ms_tick = 1'b1; step(); ms_tick = 1'b0; step();
    endtask

    task automatic pop();
        rd_pop = 1'b1; step(); rd_pop = 1'b0;
    endtask

    task automatic ack();
        flush_ack = 1'b1; step(); flush_ack = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; step(); cfg_we = 1'b0;
    endtask

    // driver side of the scoreboard: expected flush reason
    task automatic expect_flush(input logic [1:0] c);
        exp_q.push_back(c);
    endtask

    // monitor: every rising request is matched against the queue
    always @(posedge clk) begin
        #3;
        if (!rst_n) begin
            mon_prev = 1'b0;
        end else begin
            if (flush_req && !mon_prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected flush rise, cause", int'(flush_cause), 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    chk(flush_cause == e, "R3/R7/R8", "flush cause", int'(flush_cause), int'(e));
                end
            end
            mon_prev = flush_req;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-reqs: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        // R1 reset state
        chk(flush_req == 1'b0, "R1", "flush_req", int'(flush_req), 0);
        chk(flush_cause == 2'd0, "R1", "flush_cause", int'(flush_cause), 0);
        chk(level == 9'd0, "R1", "level", int'(level), 0);
        chk(buf_empty == 1'b1, "R1", "buf_empty", int'(buf_empty), 1);
        chk(buf_full == 1'b0, "R1", "buf_full", int'(buf_full), 0);
        rst_n = 1'b1;
        step();

        // R3 timeout flush, R9 absorption
        cfg(2'd0, 8'd3);
        wr_byte(8'h41);
        chk(level == 9'd1, "R2", "level after write", int'(level), 1);
        tick(); tick();
        chk(flush_req == 1'b0, "R3", "req before period", int'(flush_req), 0);
        expect_flush(2'd1);
        tick();
        chk(flush_req == 1'b1, "R3", "req at period", int'(flush_req), 1);
        chk(flush_cause == 2'd1, "R3", "cause timeout", int'(flush_cause), 1);
        for (int i = 0; i < 5; i++) tick();
        chk(flush_req == 1'b1, "R9", "req held without ack", int'(flush_req), 1);
        chk(flush_cause == 2'd1, "R9", "cause held", int'(flush_cause), 1);
        pop();
        ack();
        chk(flush_req == 1'b0, "R9", "req after ack", int'(flush_req), 0);
        chk(flush_cause == 2'd0, "R9", "cause after ack", int'(flush_cause), 0);
        for (int i = 0; i < 6; i++) tick();
        chk(flush_req == 1'b0, "R6", "no req on empty buffer", int'(flush_req), 0);

        // R5 restart on write, R9 restart after ack
        wr_byte(8'h42);
        tick(); tick();
        wr_byte(8'h43);
        tick(); tick();
        chk(flush_req == 1'b0, "R5", "req after restart", int'(flush_req), 0);
        expect_flush(2'd1);
        tick();
        chk(flush_req == 1'b1, "R5", "req period after last write", int'(flush_req), 1);
        ack();
        tick(); tick();
        chk(flush_req == 1'b0, "R9", "timer restarted by ack", int'(flush_req), 0);
        expect_flush(2'd1);
        tick();
        chk(flush_req == 1'b1, "R9", "req after restarted period", int'(flush_req), 1);
        ack();
        pop(); pop();
        chk(buf_empty == 1'b1, "R6", "drained empty", int'(buf_empty), 1);
        for (int i = 0; i < 5; i++) tick();
        chk(flush_req == 1'b0, "R6", "drained returns idle", int'(flush_req), 0);

        // R4 zero timeout
        cfg(2'd0, 8'd0);
        wr_byte(8'h44);
        expect_flush(2'd1);
        tick();
        chk(flush_req == 1'b1, "R4", "zero acts as 1ms", int'(flush_req), 1);
        pop();
        ack();
        chk(flush_req == 1'b0, "R4", "cleared", int'(flush_req), 0);

        // R8 event character
        cfg(2'd0, 8'd255);
        cfg(2'd1, 8'h0D);
        cfg(2'd2, 8'h01);
        wr_byte(8'h41);
        chk(flush_req == 1'b0, "R8", "non-event byte", int'(flush_req), 0);
        expect_flush(2'd3);
        wr_byte(8'h0D);
        chk(flush_req == 1'b1, "R8", "event flush next cycle", int'(flush_req), 1);
        chk(flush_cause == 2'd3, "R8", "cause event", int'(flush_cause), 3);
        pop(); pop();
        ack();
        expect_flush(2'd3);
        wr_byte(8'h0D);
        chk(flush_req == 1'b1, "R8", "event on empty buffer", int'(flush_req), 1);
        pop();
        ack();
        cfg(2'd2, 8'h00);
        wr_byte(8'h0D);
        step(); step(); step();
        chk(flush_req == 1'b0, "R8", "event disabled", int'(flush_req), 0);
        cfg(2'd0, 8'd2);
        tick();
        expect_flush(2'd1);
        tick();
        chk(flush_req == 1'b1, "R3", "timeout after disabled event", int'(flush_req), 1);
        pop();
        ack();

        // R2 occupancy corner cases
        wr_byte(8'h10);
        wr_valid = 1'b1; rd_pop = 1'b1; wr_data = 8'h11; step();
        wr_valid = 1'b0; rd_pop = 1'b0;
        chk(level == 9'd1, "R2", "write and pop together", int'(level), 1);
        pop();
        chk(level == 9'd0, "R2", "pop to empty", int'(level), 0);
        pop();
        chk(level == 9'd0, "R2", "pop at empty ignored", int'(level), 0);
        chk(buf_empty == 1'b1, "R2", "empty flag", int'(buf_empty), 1);

        // R7 full flush
        cfg(2'd0, 8'd255);
        for (int i = 0; i < DEPTH - 1; i++) wr_byte(8'(i));
        chk(level == 9'(DEPTH - 1), "R2", "level before full", int'(level), DEPTH - 1);
        chk(flush_req == 1'b0, "R7", "no req before full", int'(flush_req), 0);
        expect_flush(2'd2);
        wr_byte(8'h77);
        chk(buf_full == 1'b1, "R2", "full flag", int'(buf_full), 1);
        chk(flush_req == 1'b0, "R7", "req not yet", int'(flush_req), 0);
        step();
        chk(flush_req == 1'b1, "R7", "req one cycle after full", int'(flush_req), 1);
        chk(flush_cause == 2'd2, "R7", "cause full", int'(flush_cause), 2);
        wr_byte(8'h78);
        chk(level == 9'(DEPTH), "R2", "write at full ignored", int'(level), DEPTH);
        expect_flush(2'd2);
        ack();
        chk(flush_req == 1'b0, "R9", "drop on ack", int'(flush_req), 0);
        step();
        chk(flush_req == 1'b1, "R7", "re-flush still full", int'(flush_req), 1);
        rd_pop = 1'b1; flush_ack = 1'b1; step();
        rd_pop = 1'b0; flush_ack = 1'b0;
        chk(level == 9'(DEPTH - 1), "R2", "pop with ack", int'(level), DEPTH - 1);
        chk(flush_req == 1'b0, "R9", "released", int'(flush_req), 0);
        for (int i = 0; i < DEPTH - 1; i++) pop();
        chk(level == 9'd0, "R2", "drained", int'(level), 0);
        step(); step();
        chk(flush_req == 1'b0, "R6", "idle after drain", int'(flush_req), 0);
        chk(exp_q.size() == 0, "R3", "expected flushes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule